// File: doc/BRIEF.md
# Two-Output Interrupt Router with Set/Clear Enables

This block collects 32 level-sensitive interrupt requests and drives two active-high lines to a processor core: a normal request line and a fast request line. Each source has an enable bit and a routing bit. A source reaches an output only when its request is high and its enable bit is set. Its routing bit then selects the output: 0 for the normal line, 1 for the fast line. Both lines are registered OR-reductions of the masked per-source status, so they follow the inputs with one clock of latency.

Software controls the block through a word-addressed register bus with one access per cycle. It can read the unmasked request vector and the masked status for each output. Enable bits are never written directly. One offset sets every enable bit written as 1, and a second offset clears every enable bit written as 1. A single protection bit can deny register access to accesses that carry a user-mode flag. Only privileged accesses may change that protection bit.

Register offsets are fixed word indices: 0 normal-line status, 1 fast-line status, 2 unmasked requests, 3 routing, 4 enable-set, 5 enable-clear, 8 protection (bit 0). All other offsets are unmapped. Read data is registered and appears on the read-data port in the cycle after the read access. In every other cycle the port is zero.

Top module: `irq_router`

## Requirements
- R1: After reset, the enable, routing and protection registers are zero, and both output lines are low.
- R2: A read at offset 2 returns the source input vector exactly as it is, with no masking.
- R3: A read at offset 0 returns the source inputs ANDed with the enable bits and with the inverted routing bits.
- R4: A read at offset 1 returns the source inputs ANDed with the enable bits and with the routing bits.
- R5: A write at offset 4 sets each enable bit whose data bit is 1 and leaves the others unchanged. A read at offset 4 returns the current enable bits.
- R6: A write at offset 5 clears each enable bit whose data bit is 1 and leaves the others unchanged. A read at offset 5 returns zero.
- R7: Offset 3 is a read/write routing register. Bit n set to 1 routes source n to the fast line, and 0 routes it to the normal line.
- R8: While protection bit 0 at offset 8 is 1, writes with the user flag high change no register, and reads with the user flag high return zero. Privileged accesses are unaffected.
- R9: The protection bit changes only on a privileged write to offset 8, whatever its current value.
- R10: The normal line is high one cycle after any bit of the normal-line status is high. The fast line is high one cycle after any bit of the fast-line status is high.
- R11: Read data appears in the cycle after the read access and is zero in every other cycle. Writes to offsets 0, 1 and 2 and to unmapped offsets change nothing, and unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | N_SRC | Level-sensitive interrupt requests, synchronous to clk |
| acc_i | input | 1 | Register access strobe, one access per cycle |
| wr_i | input | 1 | 1 for a write access, 0 for a read access |
| addr_i | input | 4 | Register word offset |
| wdata_i | input | N_SRC | Write data |
| user_i | input | 1 | 1 when the access is made in user mode |
| rdata_o | output | N_SRC | Registered read data |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
The bench builds the block with its default of 32 sources, so the full word width is in use. That lets the tests drive bit 31 and bit 0 of every register and cover every mapped offset as well as unmapped ones such as 6 and 7. Enable patterns are built up over several set and clear writes, so the tests show both that unwritten bits keep their value and that the routing bits split one request vector across the two status words. Protection is tested in both states with user and privileged accesses, including user attempts to rewrite the protection bit itself.

// File: rtl/irq_router_pkg.sv
// Package: register offsets shared by the interrupt router modules.
// Assumes a word-addressed bus with a 4-bit offset.
package irq_router_pkg;
    localparam int OFS_W = 4;
    localparam logic [OFS_W-1:0] OFS_IRQ_STAT = 4'd0;
    localparam logic [OFS_W-1:0] OFS_FIQ_STAT = 4'd1;
    localparam logic [OFS_W-1:0] OFS_RAW      = 4'd2;
    localparam logic [OFS_W-1:0] OFS_ROUTE    = 4'd3;
    localparam logic [OFS_W-1:0] OFS_EN_SET   = 4'd4;
    localparam logic [OFS_W-1:0] OFS_EN_CLR   = 4'd5;
    localparam logic [OFS_W-1:0] OFS_PROT     = 4'd8;
endpackage

// File: rtl/irq_mask.sv
// Module: irq_mask
// Purpose: splits the request vector into the normal-line and fast-line
// status words using the enable and routing bits.
// Assumes: purely combinational; the inputs are stable within a cycle.
module irq_mask #(
    parameter int N_SRC = 32
) (
    input  logic [N_SRC-1:0] raw_i,
    input  logic [N_SRC-1:0] en_i,
    input  logic [N_SRC-1:0] route_i,
    output logic [N_SRC-1:0] irq_stat_o,
    output logic [N_SRC-1:0] fiq_stat_o
);
    // Route each enabled request to exactly one of the two status words.
    always_comb begin
        irq_stat_o = raw_i & en_i & ~route_i;
        fiq_stat_o = raw_i & en_i & route_i;
    end

    // R3/R4: together the two words cover every enabled request, and no
    // request appears in both.
    always_comb begin
        assert_split_R3: assert ((irq_stat_o | fiq_stat_o) == (raw_i & en_i));
        assert_disjoint_R4: assert ((irq_stat_o & fiq_stat_o) == '0);
    end
endmodule

// File: rtl/irq_regfile.sv
// Module: irq_regfile
// Purpose: holds the enable, routing and protection registers, decodes
// bus writes (set/clear enables) and returns registered read data.
// Assumes: at most one access per cycle; synchronous active-low reset.
module irq_regfile
    import irq_router_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_i,
    input  logic             wr_i,
    input  logic [OFS_W-1:0] addr_i,
    input  logic [N_SRC-1:0] wdata_i,
    input  logic             user_i,
    input  logic [N_SRC-1:0] raw_i,
    input  logic [N_SRC-1:0] irq_stat_i,
    input  logic [N_SRC-1:0] fiq_stat_i,
    output logic [N_SRC-1:0] en_o,
    output logic [N_SRC-1:0] route_o,
    output logic [N_SRC-1:0] rdata_o
);
    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] route_q;
    logic             prot_q;
    logic [N_SRC-1:0] rd_val;
    logic [N_SRC-1:0] rdata_q;
    logic             allowed;
    logic             wr_ok;
    logic             rd_ok;

    // Qualify accesses against the protection bit.
    always_comb begin
        allowed = !(prot_q && user_i);
        wr_ok   = acc_i && wr_i && allowed;
        rd_ok   = acc_i && !wr_i && allowed;
    end

    // Enable bits: change only through the set and clear offsets.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_ok && addr_i == OFS_EN_SET)
            en_q <= en_q | wdata_i;
        else if (wr_ok && addr_i == OFS_EN_CLR)
            en_q <= en_q & ~wdata_i;
    end

    // Routing bits: plain read/write register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            route_q <= '0;
        else if (wr_ok && addr_i == OFS_ROUTE)
            route_q <= wdata_i;
    end

    // Protection bit: privileged writes only, whatever its state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prot_q <= 1'b0;
        else if (acc_i && wr_i && !user_i && addr_i == OFS_PROT)
            prot_q <= wdata_i[0];
    end

    // Read multiplexer over the mapped offsets.
    always_comb begin
        rd_val = '0;
        case (addr_i)
            OFS_IRQ_STAT: rd_val = irq_stat_i;
            OFS_FIQ_STAT: rd_val = fiq_stat_i;
            OFS_RAW:      rd_val = raw_i;
            OFS_ROUTE:    rd_val = route_q;
            OFS_EN_SET:   rd_val = en_q;
            OFS_PROT:     rd_val = {{(N_SRC-1){1'b0}}, prot_q};
            default:      rd_val = '0;
        endcase
    end

    // Registered read data: valid the cycle after a read, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else
            rdata_q <= rd_ok ? rd_val : '0;
    end

    assign en_o    = en_q;
    assign route_o = route_q;
    assign rdata_o = rdata_q;

    // R5: a set write raises every written bit and keeps the others.
    assert_set_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && addr_i == OFS_EN_SET) |=>
            ((en_q & $past(wdata_i)) == $past(wdata_i)) &&
            ((en_q & ~$past(wdata_i)) == ($past(en_q) & ~$past(wdata_i))));

    // R6: a clear write drops every written bit and keeps the others.
    assert_clr_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && addr_i == OFS_EN_CLR) |=>
            ((en_q & $past(wdata_i)) == '0) &&
            ((en_q & ~$past(wdata_i)) == ($past(en_q) & ~$past(wdata_i))));

    // R8: a user write under protection leaves the registers untouched.
    assert_user_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && wr_i && user_i && prot_q) |=> $stable(en_q) && $stable(route_q));

    // R9: user writes never move the protection bit.
    assert_prot_priv_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && wr_i && user_i) |=> $stable(prot_q));

    // R11: read data is zero in the cycle after any non-read cycle.
    assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_i && !wr_i) |=> (rdata_q == '0));
endmodule

// File: rtl/irq_out.sv
// Module: irq_out
// Purpose: registers the OR-reduction of each status word onto the two
// interrupt lines.
// Assumes: synchronous active-low reset; one cycle of latency is allowed.
module irq_out #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_stat_i,
    input  logic [N_SRC-1:0] fiq_stat_i,
    output logic             irq_o,
    output logic             fiq_o
);
    logic irq_q;
    logic fiq_q;

    // Register the any-pending condition for each line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            fiq_q <= 1'b0;
        end else begin
            irq_q <= |irq_stat_i;
            fiq_q <= |fiq_stat_i;
        end
    end

    assign irq_o = irq_q;
    assign fiq_o = fiq_q;
endmodule

// File: rtl/irq_router.sv
// Module: irq_router (top)
// Purpose: memory-mapped interrupt controller with one enable and one
// routing bit per source, driving a normal and a fast interrupt line.
// Assumes: sources are synchronous to clk; one bus access per cycle;
// synchronous active-low reset.
module irq_router
    import irq_router_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic             acc_i,
    input  logic             wr_i,
    input  logic [3:0]       addr_i,
    input  logic [N_SRC-1:0] wdata_i,
    input  logic             user_i,
    output logic [N_SRC-1:0] rdata_o,
    output logic             irq_o,
    output logic             fiq_o
);
    logic [N_SRC-1:0] en;
    logic [N_SRC-1:0] route;
    logic [N_SRC-1:0] irq_stat;
    logic [N_SRC-1:0] fiq_stat;

    // Register file and bus decode.
    irq_regfile #(.N_SRC(N_SRC)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_i      (acc_i),
        .wr_i       (wr_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .user_i     (user_i),
        .raw_i      (src_i),
        .irq_stat_i (irq_stat),
        .fiq_stat_i (fiq_stat),
        .en_o       (en),
        .route_o    (route),
        .rdata_o    (rdata_o)
    );

    // Masking and routing.
    irq_mask #(.N_SRC(N_SRC)) u_mask (
        .raw_i      (src_i),
        .en_i       (en),
        .route_i    (route),
        .irq_stat_o (irq_stat),
        .fiq_stat_o (fiq_stat)
    );

    // Registered output lines.
    irq_out #(.N_SRC(N_SRC)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_stat_i (irq_stat),
        .fiq_stat_i (fiq_stat),
        .irq_o      (irq_o),
        .fiq_o      (fiq_o)
    );

    // R10: with no request in the previous cycle, both lines are low.
    assert_quiet_lines_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(src_i) == '0) |-> (!irq_o && !fiq_o));

    // R1: with every enable clear in the previous cycle, both lines are low.
    assert_masked_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) == '0) |-> (!irq_o && !fiq_o));
endmodule

// File: tb/irq_router_tb.sv
// Directed bench for irq_router: one task per scenario.
module irq_router_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        acc_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [3:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic        user_i = 1'b0;
    logic [31:0] rdata_o;
    logic        irq_o;
    logic        fiq_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_router #(.N_SRC(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .acc_i(acc_i), .wr_i(wr_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .user_i(user_i),
        .rdata_o(rdata_o), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bus write; called at a negedge, returns at the next negedge.
    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d, input logic usr);
        acc_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d; user_i = usr;
        @(negedge clk);
        acc_i = 1'b0; wr_i = 1'b0; wdata_i = '0; user_i = 1'b0;
    endtask

    // Bus read; data is sampled one cycle after the access.
    task automatic bus_rd(input logic [3:0] a, input logic usr, output logic [31:0] d);
        acc_i = 1'b1; wr_i = 1'b0; addr_i = a; user_i = usr;
        @(negedge clk);
        d = rdata_o;
        acc_i = 1'b0; user_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq_o after reset", {31'd0, irq_o}, 32'd0);
        check("R1 fiq_o after reset", {31'd0, fiq_o}, 32'd0);
        bus_rd(4'd4, 1'b0, d); check("R1 enable after reset", d, 32'h0);
        bus_rd(4'd3, 1'b0, d); check("R1 routing after reset", d, 32'h0);
        bus_rd(4'd8, 1'b0, d); check("R1 protection after reset", d, 32'h0);
    endtask

    task automatic t_raw();
        logic [31:0] d;
        src_i = 32'hA5A5_0001;
        bus_rd(4'd2, 1'b0, d); check("R2 raw pattern A", d, 32'hA5A5_0001);
        src_i = 32'h8000_0000;
        bus_rd(4'd2, 1'b0, d); check("R2 raw bit 31", d, 32'h8000_0000);
        bus_rd(4'd0, 1'b0, d); check("R3 no enable, no irq status", d, 32'h0);
    endtask

    task automatic t_set_clear();
        logic [31:0] d;
        bus_wr(4'd4, 32'h0000_00F0, 1'b0);
        bus_rd(4'd4, 1'b0, d); check("R5 set first group", d, 32'h0000_00F0);
        bus_wr(4'd4, 32'h0000_0F00, 1'b0);
        bus_rd(4'd4, 1'b0, d); check("R5 set keeps zero-written bits", d, 32'h0000_0FF0);
        bus_wr(4'd5, 32'h0000_0030, 1'b0);
        bus_rd(4'd4, 1'b0, d); check("R6 clear selected bits", d, 32'h0000_0FC0);
        bus_rd(4'd5, 1'b0, d); check("R6 clear offset reads zero", d, 32'h0);
        bus_wr(4'd5, 32'h0, 1'b0);
        bus_rd(4'd4, 1'b0, d); check("R6 zero clear has no effect", d, 32'h0000_0FC0);
        bus_wr(4'd4, 32'h8000_0000, 1'b0);
        bus_rd(4'd4, 1'b0, d); check("R5 set bit 31", d, 32'h8000_0FC0);
    endtask

    task automatic t_route();
        logic [31:0] d;
        src_i = 32'hFFFF_FFFF;
        bus_wr(4'd3, 32'h0000_0F00, 1'b0);
        bus_rd(4'd3, 1'b0, d); check("R7 routing readback", d, 32'h0000_0F00);
        bus_rd(4'd0, 1'b0, d); check("R3 irq status", d, 32'h8000_00C0);
        bus_rd(4'd1, 1'b0, d); check("R4 fiq status", d, 32'h0000_0F00);
        src_i = 32'h0000_0140;
        bus_rd(4'd0, 1'b0, d); check("R3 irq status partial", d, 32'h0000_0040);
        bus_rd(4'd1, 1'b0, d); check("R4 fiq status partial", d, 32'h0000_0100);
    endtask

    task automatic t_outputs();
        src_i = 32'h0;
        repeat (2) @(negedge clk);
        check("R10 idle irq_o", {31'd0, irq_o}, 32'd0);
        check("R10 idle fiq_o", {31'd0, fiq_o}, 32'd0);
        src_i = 32'h0000_0040;
        check("R10 irq_o not before edge", {31'd0, irq_o}, 32'd0);
        @(negedge clk);
        check("R10 irq_o after one cycle", {31'd0, irq_o}, 32'd1);
        check("R10 fiq_o stays low", {31'd0, fiq_o}, 32'd0);
        src_i = 32'h0000_0100;
        @(negedge clk);
        check("R10 fiq_o for fast source", {31'd0, fiq_o}, 32'd1);
        check("R10 irq_o drops", {31'd0, irq_o}, 32'd0);
        src_i = 32'h0000_0002;
        @(negedge clk);
        check("R10 disabled source irq_o", {31'd0, irq_o}, 32'd0);
        check("R10 disabled source fiq_o", {31'd0, fiq_o}, 32'd0);
    endtask

    task automatic t_protect();
        logic [31:0] d;
        bus_wr(4'd8, 32'h1, 1'b0);
        bus_rd(4'd8, 1'b0, d); check("R9 privileged sets protection", d, 32'h1);
        bus_wr(4'd4, 32'h0000_0001, 1'b1);
        bus_rd(4'd4, 1'b0, d); check("R8 user set ignored", d, 32'h8000_0FC0);
        bus_wr(4'd5, 32'hFFFF_FFFF, 1'b1);
        bus_rd(4'd4, 1'b0, d); check("R8 user clear ignored", d, 32'h8000_0FC0);
        bus_wr(4'd3, 32'hFFFF_FFFF, 1'b1);
        bus_rd(4'd3, 1'b0, d); check("R8 user routing write ignored", d, 32'h0000_0F00);
        bus_rd(4'd4, 1'b1, d); check("R8 user read returns zero", d, 32'h0);
        bus_wr(4'd8, 32'h0, 1'b1);
        bus_rd(4'd8, 1'b0, d); check("R9 user cannot drop protection", d, 32'h1);
        bus_wr(4'd8, 32'h0, 1'b0);
        bus_rd(4'd4, 1'b1, d); check("R8 user read allowed when off", d, 32'h8000_0FC0);
        bus_wr(4'd8, 32'h1, 1'b1);
        bus_rd(4'd8, 1'b0, d); check("R9 user cannot raise protection", d, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        src_i = 32'h1234_5678;
        bus_wr(4'd2, 32'hFFFF_FFFF, 1'b0);
        bus_rd(4'd2, 1'b0, d); check("R11 raw not writable", d, 32'h1234_5678);
        bus_wr(4'd0, 32'hFFFF_FFFF, 1'b0);
        bus_wr(4'd6, 32'hFFFF_FFFF, 1'b0);
        bus_rd(4'd4, 1'b0, d); check("R11 writes to status/unmapped ignored", d, 32'h8000_0FC0);
        bus_rd(4'd3, 1'b0, d); check("R11 routing untouched", d, 32'h0000_0F00);
        bus_rd(4'd7, 1'b0, d); check("R11 unmapped reads zero", d, 32'h0);
        @(negedge clk);
        check("R11 rdata zero when idle", rdata_o, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_raw();
        t_set_clear();
        t_route();
        t_outputs();
        t_protect();
        t_unmapped();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule